// File: doc/BRIEF.md
# Multi-Peak Lookahead Correction Stage

This stage sits in a crest-factor-reduction chain. It comes after the unit that turns clipping gains into a peak-excess stream, and before the peak window filter. Each input sample is the amount a sample must be pulled down, that is one minus the clipping gain, as unsigned fixed point. An isolated peak makes a single nonzero sample. Two peaks that sit closer together than half a window overlap inside the window filter, and the earlier peak is then over-suppressed.

The stage holds every sample back by half a window length. This lets the samples that arrive after it be seen while it is still held. It then forms the weighted sum of those later samples, using the first-half window weights. It leaves out a programmable number of taps next to the centre, and subtracts a programmable fraction of the sum from the held sample. The result is saturated to the range from zero to the uncorrected value. A valid strobe travels with the data.

A two-state control sequence runs after reset. `ST_PRIME` holds the output strobe low while the delay line fills. It lasts HALF cycles, and on its last count it takes the transition PRIME→RUN. `ST_RUN` then passes corrected samples through for good.

Top module: `cfr_multipeak_corrector`

## Requirements
- R1: A sample presented with `in_valid` high before clock edge e appears on `out_data` with `out_valid` high after edge e+HALF. Default HALF is 40.
- R2: A sample with no valid nonzero sample in the HALF samples after it leaves unchanged.
- R3: Take the sample at position n and let x(m) be the input at position m. The sum is S = Σ x(n+k)·w(k) over k = 1..HALF, with k > `cfg_excl`. The weight is w(k) = floor((HALF+1−k)·256/(HALF+1)). Then C = floor(S/256), D = floor(C·`cfg_frac`/16), and the output is x(n)−D when that is positive.
- R4: Taps whose offset k is less than or equal to `cfg_excl` add nothing to the sum. When `cfg_excl` ≥ HALF, every sample passes unchanged.
- R5: `cfg_frac` is an unsigned fraction in sixteenths. A value of 0 leaves every sample unchanged.
- R6: When D ≥ x(n), the output is 0.
- R7: An output sample never exceeds its uncorrected input value.
- R8: A sample presented with `in_valid` low counts as zero for every correction. Its output slot has `out_valid` low and `out_data` equal to 0.
- R9: While reset is held, and in the `ST_PRIME` state after it, `out_valid` is 0 and `out_data` is 0.
- R10: Samples more than HALF positions after a sample have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W (12) | Peak-excess sample, one minus clipping gain |
| cfg_excl | input | EXCL_W (6) | Count of centre-nearest taps left out of the sum |
| cfg_frac | input | 4 | Correction fraction in sixteenths |
| out_valid | output | 1 | Output sample strobe, HALF cycles after input |
| out_data | output | DATA_W (12) | Corrected peak-excess sample |

## Verification
On every cycle, the assertions check these properties:
- Each output stays at or below the held sample it came from.
- A zero fraction or full tap exclusion gives pass-through.
- Empty slots carry zero.
- The strobe stays low during priming.

Only the bench's scenarios can show the following:
- The exact fixed-point amount taken from an earlier peak by one or several later ones.
- The exact boundary of the exclusion count and of the half-window reach.
- The exact output latency.

For each scenario, the bench compares every output slot against a model of the R3 arithmetic.

// File: rtl/cfr_mpc_pkg.sv
package cfr_mpc_pkg;

    localparam int COEF_W = 8;
    localparam int FRAC_W = 4;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } mpc_state_e;

    // Triangular first-half window weight for offset k (1..half) from centre.
    function automatic logic [COEF_W-1:0] tri_coef(input int k, input int half);
        int v;
        v = ((half + 1 - k) * (1 << COEF_W)) / (half + 1);
        return v[COEF_W-1:0];
    endfunction

endpackage

// File: rtl/mpc_delay_line.sv
module mpc_delay_line
    import cfr_mpc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int HALF   = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    output logic [HALF-1:0][DATA_W-1:0]   stage_data,
    output logic                          tail_valid
);

    logic [HALF-1:0]             vld;
    logic [HALF-1:0][DATA_W-1:0] dat;

    for (genvar j = 0; j < HALF; j++) begin : g_stage
        if (j == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld[0] <= 1'b0;
                    dat[0] <= '0;
                end else begin
                    vld[0] <= in_valid;
                    dat[0] <= in_valid ? in_data : '0;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld[j] <= 1'b0;
                    dat[j] <= '0;
                end else begin
                    vld[j] <= vld[j-1];
                    dat[j] <= dat[j-1];
                end
            end
        end
    end

    assign stage_data = dat;
    assign tail_valid = vld[HALF-1];

    // R8
    empty_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tail_valid |-> stage_data[HALF-1] == '0);

endmodule

// File: rtl/mpc_lookahead_sum.sv
module mpc_lookahead_sum
    import cfr_mpc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int HALF   = 40,
    parameter int EXCL_W = $clog2(HALF + 1),
    localparam int SUM_W = DATA_W + COEF_W + $clog2(HALF + 1),
    localparam int CON_W = SUM_W - COEF_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    input  logic [HALF-1:0][DATA_W-1:0]   stage_data,
    input  logic [EXCL_W-1:0]             cfg_excl,
    output logic [CON_W-1:0]              contrib
);

    logic [HALF:1][SUM_W-1:0] term;
    logic [SUM_W-1:0]         acc;

    for (genvar k = 1; k <= HALF; k++) begin : g_tap
        localparam logic [COEF_W-1:0] WGT = tri_coef(k, HALF);
        logic [DATA_W-1:0] smp;
        if (k == HALF) begin : g_live
            assign smp = in_valid ? in_data : '0;
        end else begin : g_held
            assign smp = stage_data[HALF-1-k];
        end
        assign term[k] = (int'(cfg_excl) < k) ? (SUM_W'(smp) * SUM_W'(WGT)) : '0;
    end

    always_comb begin
        acc = '0;
        for (int k = 1; k <= HALF; k++) begin
            acc = acc + term[k];
        end
    end

    assign contrib = acc[SUM_W-1:COEF_W];

    // R4
    full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_excl) >= HALF) |-> contrib == '0);

endmodule

// File: rtl/cfr_multipeak_corrector.sv
module cfr_multipeak_corrector
    import cfr_mpc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int HALF   = 40,
    parameter int EXCL_W = $clog2(HALF + 1),
    localparam int SUM_W = DATA_W + COEF_W + $clog2(HALF + 1),
    localparam int CON_W = SUM_W - COEF_W,
    localparam int CNT_W = $clog2(HALF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [EXCL_W-1:0] cfg_excl,
    input  logic [FRAC_W-1:0] cfg_frac,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [HALF-1:0][DATA_W-1:0] stage_data;
    logic                        tail_valid;
    logic [DATA_W-1:0]           tail_data;
    logic [CON_W-1:0]            contrib;
    logic [CON_W+FRAC_W-1:0]     scaled;
    logic [CON_W-1:0]            corr;
    logic [DATA_W-1:0]           nxt_data;
    mpc_state_e                  state;
    logic [CNT_W-1:0]            cnt;

    mpc_delay_line #(.DATA_W(DATA_W), .HALF(HALF)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .stage_data (stage_data),
        .tail_valid (tail_valid)
    );

    mpc_lookahead_sum #(.DATA_W(DATA_W), .HALF(HALF), .EXCL_W(EXCL_W)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .stage_data (stage_data),
        .cfg_excl   (cfg_excl),
        .contrib    (contrib)
    );

    assign tail_data = stage_data[HALF-1];
    assign scaled    = (CON_W+FRAC_W)'(contrib) * (CON_W+FRAC_W)'(cfg_frac);
    assign corr      = scaled[CON_W+FRAC_W-1:FRAC_W];

    always_comb begin
        if (corr >= CON_W'(tail_data)) begin
            nxt_data = '0;
        end else begin
            nxt_data = tail_data - corr[DATA_W-1:0];
        end
    end

    // State register: prime the delay line, then run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PRIME;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_PRIME: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(HALF - 1)) begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt;
                end
                default: begin
                    state <= ST_PRIME;
                end
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            unique case (state)
                ST_PRIME: begin
                    out_valid <= 1'b0;
                    out_data  <= '0;
                end
                ST_RUN: begin
                    out_valid <= tail_valid;
                    out_data  <= nxt_data;
                end
                default: begin
                    out_valid <= 1'b0;
                    out_data  <= '0;
                end
            endcase
        end
    end

    // R7
    no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_data <= $past(tail_data));

    // R5
    zero_frac_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_frac) == '0 && $past(state) == ST_RUN) |-> out_data == $past(tail_data));

    // R8
    idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0);

    // R9
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PRIME |-> (!out_valid && out_data == '0));

endmodule

// File: tb/cfr_multipeak_corrector_bench.sv
`timescale 1ns/1ps
module cfr_multipeak_corrector_bench;

    localparam int DATA_W = 12;
    localparam int HALF   = 40;
    localparam int EXCL_W = $clog2(HALF + 1);
    localparam int LEN    = 3 * HALF;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic [EXCL_W-1:0] cfg_excl;
    logic [3:0]        cfg_frac;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cur_r;
    int cur_a;
    int stim_d [LEN];
    bit stim_v [LEN];

    always #2.5 clk = ~clk;

    cfr_multipeak_corrector #(.DATA_W(DATA_W), .HALF(HALF)) u_cfr_multipeak_corrector (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_excl  (cfg_excl),
        .cfg_frac  (cfg_frac),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int xeff(int m);
        if (m < LEN && stim_v[m]) return stim_d[m];
        return 0;
    endfunction

    // Model of the correction arithmetic stated in R3.
    function automatic int exp_out(int n);
        int s, c, d, x;
        if (!stim_v[n]) return 0;
        s = 0;
        for (int k = 1; k <= HALF; k++) begin
            if (k > cur_r) s += xeff(n + k) * (((HALF + 1 - k) * 256) / (HALF + 1));
        end
        c = s / 256;
        d = (c * cur_a) / 16;
        x = stim_d[n];
        return (x > d) ? x - d : 0;
    endfunction

    task automatic clear_stim();
        for (int i = 0; i < LEN; i++) begin
            stim_d[i] = 0;
            stim_v[i] = 1'b1;
        end
    endtask

    task automatic run_case(string req, string name, int r, int a);
        int idx, ed;
        bit ev;
        cur_r = r;
        cur_a = a;
        cfg_excl = EXCL_W'(r);
        cfg_frac = 4'(a);
        for (int i = 0; i <= LEN + HALF; i++) begin
            @(negedge clk);
            if (i >= HALF + 1) begin
                idx = i - HALF - 1;
                ev  = stim_v[idx];
                ed  = exp_out(idx);
                n_checks++;
                if (out_valid !== ev || int'(out_data) != ed) begin
                    n_fails++;
                    $display("FAIL %s %s slot %0d: valid=%0b data=%0d expected valid=%0b data=%0d",
                             req, name, idx, out_valid, out_data, ev, ed);
                end
                if (ev) begin
                    n_checks++;
                    // R7
                    if (int'(out_data) > stim_d[idx]) begin
                        n_fails++;
                        $display("FAIL R7 %s slot %0d: data=%0d expected at most %0d",
                                 name, idx, out_data, stim_d[idx]);
                    end
                end
            end
            if (i < LEN) begin
                in_valid = stim_v[i];
                in_data  = DATA_W'(stim_d[i]);
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fails++;
            $display("FAIL R9 reset: valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
        end
    endtask

    task automatic t_latency();
        clear_stim();
        for (int i = 0; i < LEN; i++) stim_v[i] = (i % 7 == 3);
        stim_d[3] = 1200; stim_d[52] = 800;
        run_case("R1", "latency", 0, 8);
    endtask

    task automatic t_isolated();
        clear_stim();
        stim_d[10] = 3000;
        stim_d[70] = 4095;
        run_case("R2", "isolated", 0, 15);
    endtask

    task automatic t_pair();
        clear_stim();
        stim_d[10] = 2000; stim_d[20] = 3000;
        run_case("R3", "pair", 0, 4);
    endtask

    task automatic t_cluster();
        clear_stim();
        stim_d[30] = 1500; stim_d[33] = 2500; stim_d[45] = 3500; stim_d[60] = 1000;
        run_case("R3", "cluster", 2, 6);
    endtask

    task automatic t_exclude();
        clear_stim();
        stim_d[10] = 2000; stim_d[20] = 3000;
        run_case("R4", "excl_at_offset", 10, 15);
        run_case("R4", "excl_below_offset", 9, 15);
        clear_stim();
        stim_d[10] = 2000; stim_d[11] = 3000;
        run_case("R4", "excl_all", HALF, 15);
    endtask

    task automatic t_frac_zero();
        clear_stim();
        stim_d[10] = 2000; stim_d[12] = 4000;
        run_case("R5", "frac_zero", 0, 0);
    endtask

    task automatic t_saturate();
        clear_stim();
        stim_d[10] = 100; stim_d[11] = 4000;
        run_case("R6", "saturate", 0, 15);
    endtask

    task automatic t_reach();
        clear_stim();
        stim_d[10] = 2000; stim_d[50] = 4000;
        stim_d[70] = 2000; stim_d[111] = 4000;
        run_case("R10", "reach", 0, 15);
    endtask

    task automatic t_invalid();
        clear_stim();
        stim_d[10] = 2000;
        stim_d[13] = 4000; stim_v[13] = 1'b0;
        run_case("R8", "invalid", 0, 15);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        cfg_excl = '0;
        cfg_frac = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_isolated();
        t_pair();
        t_cluster();
        t_exclude();
        t_frac_zero();
        t_saturate();
        t_reach();
        t_invalid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule